// File: doc/BRIEF.md
# Complementary PWM Gate Generator with Dead Band

This block converts a duty word into a fixed-frequency pair of complementary gate signals for one leg of a bridge power stage. A free-running down counter sets the period. A toggle flip-flop flips on every reload, and a one-cycle period tick is derived from it. At the start of each period the commanded level comes from a sign bit that describes the latest switching-surface sample. That level is held until the counter reaches the latched duty word. The command then moves to the opposite level for the rest of the period. At most one switch happens in each period.

Each of the two gates passes through its own dead-band stage. A gate turns on only after its raw command has been high for a fixed number of clocks. It turns off in the same cycle that its command drops. The two gates can therefore never conduct together.

A controller that computes the duty word strobes it in with a valid bit. The word acts in the current period if it arrives early enough, and otherwise from the next period.

Top module: `bpwm_bridge`

Both state machines are in the level controller and the dead-band stage. The level controller has two states. `LV_HOLD` keeps the period's initial level and takes the transition to `LV_DONE` when the counter is at or below a non-zero active duty. `LV_DONE` waits for the reload, which always returns it to `LV_HOLD` with the new initial level. Each dead-band stage has three states:
- `DB_OFF` goes to `DB_WAIT` when its raw command rises.
- `DB_WAIT` counts clocks. It goes back to `DB_OFF` if the command falls, and goes to `DB_ON` once the dead time has elapsed.
- `DB_ON` drives the gate and goes to `DB_OFF` when the command falls.

## Requirements
- R1: While `rst` is high, `gate_hi`, `gate_lo` and `period_tick` are all 0. After release the counter starts from 255, and the first tick comes 256 clocks later.
- R2: `period_tick` is high for exactly one clock in the first cycle of every period, and ticks are exactly 256 clocks apart.
- R3: `surf_neg` is sampled only in the last cycle of a period (counter value 0). A value of 1 makes the next period start with the high-side command, and a value of 0 makes it start with the low-side command. Changes at any other time have no effect.
- R4: With an active duty d (1..255), the command switches to the opposite level once, so that the opposite level occupies exactly the last d cycles of the period. With d = 0 there is no switch in that period.
- R5: `duty_in` is captured only in a cycle with `duty_vld` = 1. The counter in cycle i after the tick is 255 − i. If the strobe lands in a cycle whose counter value is greater than the word, and no switch has occurred yet, the word takes effect in that period. Otherwise it takes effect from the next period. A strobe in the last cycle of a period applies to the next period.
- R6: A gate rises 3 clocks after its raw command rises and falls in the cycle in which the command falls. A command pulse of 3 clocks or fewer yields no gate pulse.
- R7: `gate_hi` and `gate_lo` are never high in the same cycle.
- R8: With the same sign s and duty d held for two periods, the second period has the following gate-on counts. For d = 0, the initial-side gate is on 256 clocks and the other gate 0. Otherwise, the initial-side gate is on max(0, 253 − d) clocks and the opposite gate max(0, d − 3) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | 8 | Duty word: clocks at the opposite level at the end of a period |
| duty_vld | input | 1 | Capture strobe for `duty_in` |
| surf_neg | input | 1 | Sign of the surface sample; 1 selects a high-side start |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| period_tick | output | 1 | One-clock pulse at the start of each period |

## Verification
The properties assume `rst` is held for at least one clock and that the inputs are steady around each rising edge. They place no limit on when `duty_vld` or `surf_neg` may change. The single-switch and sign-sampling properties therefore have to hold for strobes at any counter value, including the reload cycle. The stimulus drives every input on the falling edge. It deliberately places strobes early, late and in the reload cycle, moves `surf_neg` in mid-period, and toggles `duty_in` while `duty_vld` is low.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
    typedef enum logic {
        LV_HOLD,
        LV_DONE
    } lvl_state_t;

    typedef enum logic [1:0] {
        DB_OFF,
        DB_WAIT,
        DB_ON
    } db_state_t;
endpackage

// File: rtl/bpwm_timer.sv
module bpwm_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             reload,
    output logic             tick
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             half_q;
    logic             half_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= TOP;
            half_q <= 1'b0;
            half_d <= 1'b0;
        end else begin
            half_d <= half_q;
            if (cnt_q == '0) begin
                cnt_q  <= TOP;
                half_q <= ~half_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt    = cnt_q;
    assign reload = (cnt_q == '0);
    assign tick   = half_q ^ half_d;
endmodule

// File: rtl/bpwm_level.sv
module bpwm_level
    import bpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic             reload,
    input  logic [CNT_W-1:0] duty_in,
    input  logic             duty_vld,
    input  logic             surf_neg,
    output logic             cmd
);
    lvl_state_t       st_q, st_n;
    logic             cmd_q, cmd_n;
    logic [CNT_W-1:0] act_q, act_n;
    logic [CNT_W-1:0] nxt_q, nxt_n;
    logic             early;
    logic             hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LV_HOLD;
            cmd_q <= 1'b0;
            act_q <= '0;
            nxt_q <= '0;
        end else begin
            st_q  <= st_n;
            cmd_q <= cmd_n;
            act_q <= act_n;
            nxt_q <= nxt_n;
        end
    end

    always_comb begin
        early = duty_vld && (cnt > duty_in);
        hit   = (act_q != '0) && (cnt <= act_q);
        st_n  = st_q;
        cmd_n = cmd_q;
        act_n = early ? duty_in : act_q;
        nxt_n = duty_vld ? duty_in : nxt_q;
        if (reload) begin
            st_n  = LV_HOLD;
            cmd_n = surf_neg;
            act_n = duty_vld ? duty_in : nxt_q;
        end else begin
            unique case (st_q)
                LV_HOLD: begin
                    if (hit) begin
                        cmd_n = ~cmd_q;
                        st_n  = LV_DONE;
                    end
                end
                LV_DONE: begin
                    st_n = LV_DONE;
                end
            endcase
        end
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband
    import bpwm_pkg::*;
#(
    parameter int DEAD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic gate
);
    localparam int DC_W = $clog2(DEAD + 1);
    localparam logic [DC_W-1:0] LAST = DC_W'(DEAD - 1);
    localparam logic [DC_W-1:0] ONE  = DC_W'(1);

    db_state_t       st_q, st_n;
    logic [DC_W-1:0] dc_q, dc_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= DB_OFF;
            dc_q <= '0;
        end else begin
            st_q <= st_n;
            dc_q <= dc_n;
        end
    end

    always_comb begin
        st_n = st_q;
        dc_n = dc_q;
        unique case (st_q)
            DB_OFF: begin
                if (raw) begin
                    st_n = DB_WAIT;
                    dc_n = ONE;
                end
            end
            DB_WAIT: begin
                if (!raw) begin
                    st_n = DB_OFF;
                    dc_n = '0;
                end else if (dc_q == LAST) begin
                    st_n = DB_ON;
                end else begin
                    dc_n = dc_q + ONE;
                end
            end
            DB_ON: begin
                if (!raw) begin
                    st_n = DB_OFF;
                    dc_n = '0;
                end
            end
            default: begin
                st_n = DB_OFF;
                dc_n = '0;
            end
        endcase
    end

    assign gate = (st_q == DB_ON) && raw;
endmodule

// File: rtl/bpwm_bridge.sv
module bpwm_bridge #(
    parameter int CNT_W = 8,
    parameter int DEAD  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_in,
    input  logic             duty_vld,
    input  logic             surf_neg,
    output logic             gate_hi,
    output logic             gate_lo,
    output logic             period_tick
);
    localparam int LEGS = 2;

    logic [CNT_W-1:0] cnt;
    logic             reload;
    logic             cmd_q;
    logic [LEGS-1:0]  raw;
    logic [LEGS-1:0]  gates;

    bpwm_timer #(.CNT_W(CNT_W)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .cnt    (cnt),
        .reload (reload),
        .tick   (period_tick)
    );

    bpwm_level #(.CNT_W(CNT_W)) level_i (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .reload   (reload),
        .duty_in  (duty_in),
        .duty_vld (duty_vld),
        .surf_neg (surf_neg),
        .cmd      (cmd_q)
    );

    assign raw[0] = cmd_q;
    assign raw[1] = ~cmd_q;

    for (genvar g = 0; g < LEGS; g++) begin : g_side
        bpwm_deadband #(.DEAD(DEAD)) db_i (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw[g]),
            .gate (gates[g])
        );
    end

    assign gate_hi = gates[0];
    assign gate_lo = gates[1];
endmodule

// File: rtl/bpwm_bridge_chk.sv
module bpwm_bridge_chk #(
    parameter int CNT_W = 8,
    parameter int DEAD  = 3
) (
    input logic clk,
    input logic rst,
    input logic surf_neg,
    input logic gate_hi,
    input logic gate_lo,
    input logic period_tick,
    input logic cmd_q
);
    localparam int PERIOD = 1 << CNT_W;

    logic [CNT_W:0] gap;
    logic           seen;
    logic [7:0]     run_hi;
    logic [7:0]     run_lo;
    logic           cmd_d;
    logic [1:0]     sw_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            seen   <= 1'b0;
            run_hi <= '0;
            run_lo <= '0;
            cmd_d  <= 1'b0;
            sw_cnt <= '0;
        end else begin
            cmd_d <= cmd_q;
            if (period_tick) begin
                gap  <= '0;
                seen <= 1'b1;
            end else begin
                gap <= gap + 1'b1;
            end
            run_hi <= !cmd_q ? 8'd0 : (run_hi == 8'hFF ? run_hi : run_hi + 8'd1);
            run_lo <=  cmd_q ? 8'd0 : (run_lo == 8'hFF ? run_lo : run_lo + 8'd1);
            if (period_tick)
                sw_cnt <= '0;
            else if (cmd_q != cmd_d && sw_cnt != 2'd3)
                sw_cnt <= sw_cnt + 2'd1;
        end
    end

    // R7
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    // R2
    a_r2_period: assert property (@(posedge clk) disable iff (rst)
        (period_tick && seen) |-> (gap == (CNT_W+1)'(PERIOD - 1)));

    // R3
    a_r3_sign_sampled: assert property (@(posedge clk) disable iff (rst)
        period_tick |-> (cmd_q == $past(surf_neg)));

    // R4
    a_r4_single_switch: assert property (@(posedge clk) disable iff (rst)
        sw_cnt <= 2'd1);

    // R6
    a_r6_hi_rise_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> (run_hi == 8'(DEAD)));

    a_r6_lo_rise_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> (run_lo == 8'(DEAD)));

    a_r6_gate_needs_run: assert property (@(posedge clk) disable iff (rst)
        (gate_hi |-> run_hi >= 8'(DEAD)) and (gate_lo |-> run_lo >= 8'(DEAD)));
endmodule

bind bpwm_bridge bpwm_bridge_chk #(.CNT_W(CNT_W), .DEAD(DEAD)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .surf_neg    (surf_neg),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .period_tick (period_tick),
    .cmd_q       (cmd_q)
);

// File: tb/bpwm_bridge_tb_top.sv
`timescale 1ns/1ps
module bpwm_bridge_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] duty_in = 8'd0;
    logic       duty_vld = 1'b0;
    logic       surf_neg = 1'b0;
    logic       gate_hi;
    logic       gate_lo;
    logic       period_tick;

    int nchk = 0;
    int nfail = 0;
    int i_pos = 0;
    int ovl = 0;
    int tk_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bpwm_bridge dut_i (
        .clk         (clk),
        .rst         (rst),
        .duty_in     (duty_in),
        .duty_vld    (duty_vld),
        .surf_neg    (surf_neg),
        .gate_hi     (gate_hi),
        .gate_lo     (gate_lo),
        .period_tick (period_tick)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        i_pos = (i_pos + 1) % 256;
        if (gate_hi && gate_lo) ovl++;
        if (period_tick != (i_pos == 0)) tk_err++;
    endtask

    task automatic run_to(input int target);
        while (i_pos != target) step();
    endtask

    function automatic int pos0(input int v);
        return (v > 0) ? v : 0;
    endfunction

    initial begin
        #950000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int bad;
        int k;
        int hc;
        int lc;
        int exp_i;
        int exp_o;
        // R1: reset state
        bad = 0;
        repeat (4) begin
            @(negedge clk);
            if (gate_hi || gate_lo || period_tick) bad++;
        end
        chk(bad == 0, "R1 outputs low in reset", bad, 0);
        rst = 1'b0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!period_tick && k < 400);
        chk(k == 256, "R1 first tick after release", k, 256);
        i_pos = 0;
        run_to(255);

        // R8 / R4 / R5 sweep over both signs and many duty words
        for (int s = 1; s >= 0; s--) begin
            for (int d = 0; d < 256; d++) begin
                if (!(d < 8 || d > 247 || d % 7 == 0)) continue;
                surf_neg = s[0];
                duty_in  = 8'(d);
                duty_vld = 1'b1;
                step();
                duty_vld = 1'b0;
                duty_in  = ~8'(d);
                repeat (255) step();
                hc = 0;
                lc = 0;
                repeat (256) begin
                    step();
                    if (gate_hi) hc++;
                    if (gate_lo) lc++;
                end
                if (d == 0) begin
                    exp_i = 256;
                    exp_o = 0;
                end else begin
                    exp_i = pos0(253 - d);
                    exp_o = pos0(d - 3);
                end
                if (s == 1) begin
                    chk(hc == exp_i, $sformatf("R8 R6 initial gate s=%0d d=%0d", s, d), hc, exp_i);
                    chk(lc == exp_o, $sformatf("R4 R6 opposite gate s=%0d d=%0d", s, d), lc, exp_o);
                end else begin
                    chk(lc == exp_i, $sformatf("R8 R6 initial gate s=%0d d=%0d", s, d), lc, exp_i);
                    chk(hc == exp_o, $sformatf("R4 R6 opposite gate s=%0d d=%0d", s, d), hc, exp_o);
                end
            end
        end

        // R5: late strobe deferred, early strobe applied
        surf_neg = 1'b1;
        duty_in  = 8'd20;
        duty_vld = 1'b1;
        step();
        duty_vld = 1'b0;
        repeat (511) step();
        run_to(195);
        duty_in  = 8'd100;
        duty_vld = 1'b1;
        step();
        duty_vld = 1'b0;
        duty_in  = 8'd7;
        run_to(230);
        chk(gate_hi == 1'b1, "R5 late word not used yet", gate_hi, 1);
        run_to(240);
        chk(gate_hi == 1'b0, "R5 old word still switches", gate_hi, 0);
        run_to(150);
        chk(gate_hi == 1'b1, "R5 late word next period before", gate_hi, 1);
        run_to(160);
        chk(gate_hi == 1'b0, "R5 late word next period after", gate_hi, 0);
        run_to(50);
        duty_in  = 8'd150;
        duty_vld = 1'b1;
        step();
        duty_vld = 1'b0;
        run_to(100);
        chk(gate_hi == 1'b1, "R5 early word before switch", gate_hi, 1);
        run_to(110);
        chk(gate_hi == 1'b0, "R5 early word same period", gate_hi, 0);

        // R3: sign ignored mid-period, sampled at reload
        run_to(100);
        surf_neg = 1'b0;
        run_to(200);
        chk(gate_lo == 1'b1 && gate_hi == 1'b0, "R3 mid-period sign ignored",
            {gate_hi, gate_lo}, 1);
        run_to(50);
        chk(gate_lo == 1'b1 && gate_hi == 1'b0, "R3 low-side start after reload",
            {gate_hi, gate_lo}, 1);
        run_to(200);
        chk(gate_hi == 1'b1 && gate_lo == 1'b0, "R3 R4 switch to high side",
            {gate_hi, gate_lo}, 2);
        run_to(255);

        chk(ovl == 0, "R7 gates overlap cycles", ovl, 0);
        chk(tk_err == 0, "R2 tick spacing errors", tk_err, 0);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule